// File: doc/BRIEF.md
# Debounced Zero-Crossing Detector

This block watches a stream of signed samples, one per sample-valid strobe, and tracks which side of zero the signal is on. A change of sign is not trusted by itself. The opposite sign must persist for a programmable number of consecutive valid samples before the block accepts it as the new polarity. This prevents a noisy signal that chatters around zero during one real transition from producing several triggers.

Each accepted polarity change can raise a single-cycle update pulse. A direction select decides which changes produce that pulse. In "either" mode every accepted change fires, which gives one pulse per half cycle. In the rising-only and falling-only modes the block fires once per full cycle. A downstream measurement, such as an RMS accumulator, can use the pulse to frame its window.

Top module: `zero_cross_detect`

## Requirements
- R1: While reset is high and on the first cycle after it, `upd_o` is 0 and `pol_o` is 0.
- R2: The first valid sample after reset sets `pol_o` to that sample's sign. No pulse is raised for it. `pol_o` is 1 for a negative sample and 0 for a non-negative one.
- R3: A sample equal to zero counts as non-negative (sign 0).
- R4: `pol_o` takes a new sign only after that sign has been seen on N consecutive valid samples, where N is `dbn_len_i`. The change shows on the cycle after the Nth such sample is presented. Any `upd_o` pulse rises on that same cycle and lasts exactly one clock.
- R5: A valid sample whose sign equals the current `pol_o` clears the run of opposite samples. Chatter around zero therefore yields at most one accepted change per real transition.
- R6: Cycles with `smp_vld_i` low change nothing: neither `pol_o` nor the run count moves, and `upd_o` is 0 on the following cycle.
- R7: `dir_i` = 0 (either) or 3 (treated as either) pulses on every accepted change.
- R8: `dir_i` = 1 (rising) pulses only on a change from negative to non-negative. `pol_o` still tracks falling changes, but they raise no pulse.
- R9: `dir_i` = 2 (falling) pulses only on a change from non-negative to negative.
- R10: A `dbn_len_i` of 0 or 1 accepts a new sign on its first opposite sample, so alternating samples flip `pol_o` and pulse on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | SAMPLE_W | Signed sample |
| dir_i | input | 2 | Crossing select: 0 either, 1 rising, 2 falling, 3 either |
| dbn_len_i | input | CNT_W | Required run length of the new sign |
| upd_o | output | 1 | One-cycle crossing pulse |
| pol_o | output | 1 | Debounced polarity, 1 = negative |

## Verification
Two events meet on one clock edge: the debounce stage accepting a new sign, and the direction gate deciding on the pulse. The pulse must appear on the same cycle as the polarity flip, never one cycle later.

The bench provokes this coincidence in every mode. It also uses a run length of 1 with alternating signs, so that an acceptance falls on every edge and the pulses run back to back. The scoreboard predicts both outputs for each edge and compares them together at the falling edge that follows.

// File: rtl/zc_pkg.sv
package zc_pkg;

    typedef enum logic [1:0] {
        DIR_EITHER = 2'd0,
        DIR_RISE   = 2'd1,
        DIR_FALL   = 2'd2,
        DIR_ALT    = 2'd3
    } dir_mode_e;

    typedef struct packed {
        logic accept;
        logic new_neg;
    } flip_evt_t;

    // A new polarity fires the pulse under the given mode.
    // new_neg = 0 means a rising change (negative to non-negative).
    function automatic logic fire_on(input dir_mode_e mode, input logic new_neg);
        case (mode)
            DIR_RISE: return !new_neg;
            DIR_FALL: return new_neg;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/zc_sign_slicer.sv
module zc_sign_slicer #(
    parameter int SAMPLE_W = 16
) (
    input  logic signed [SAMPLE_W-1:0] smp,
    output logic                       neg
);
    // Zero lands on the non-negative side.
    assign neg = smp[SAMPLE_W-1];
endmodule

// File: rtl/zc_debounce.sv
module zc_debounce #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  logic             raw_neg,
    input  logic [CNT_W-1:0] len,
    output zc_pkg::flip_evt_t evt,
    output logic             pol
);
    import zc_pkg::*;

    logic             primed_q;
    logic             pol_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W:0]   need;
    logic [CNT_W:0]   run_nxt;

    assign need    = (len == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, len};
    assign run_nxt = {1'b0, run_q} + 1'b1;

    always_comb begin
        evt.accept  = vld && primed_q && (raw_neg != pol_q) && (run_nxt >= need);
        evt.new_neg = raw_neg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            primed_q <= 1'b0;
            pol_q    <= 1'b0;
            run_q    <= '0;
        end else if (vld) begin
            if (!primed_q) begin
                primed_q <= 1'b1;
                pol_q    <= raw_neg;
                run_q    <= '0;
            end else if (raw_neg == pol_q) begin
                run_q <= '0;
            end else if (evt.accept) begin
                pol_q <= raw_neg;
                run_q <= '0;
            end else begin
                run_q <= run_nxt[CNT_W-1:0];
            end
        end
    end

    assign pol = pol_q;
endmodule

// File: rtl/zc_edge_gate.sv
module zc_edge_gate (
    input  logic              clk,
    input  logic              rst,
    input  zc_pkg::flip_evt_t evt,
    input  logic [1:0]        dir,
    output logic              upd
);
    import zc_pkg::*;

    dir_mode_e mode;
    logic      upd_q;

    assign mode = dir_mode_e'(dir);

    always_ff @(posedge clk) begin
        if (rst) upd_q <= 1'b0;
        else     upd_q <= evt.accept && fire_on(mode, evt.new_neg);
    end

    assign upd = upd_q;
endmodule

// File: rtl/zero_cross_detect.sv
module zero_cross_detect #(
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_vld_i,
    input  logic signed [SAMPLE_W-1:0] smp_i,
    input  logic [1:0]                 dir_i,
    input  logic [CNT_W-1:0]           dbn_len_i,
    output logic                       upd_o,
    output logic                       pol_o
);
    import zc_pkg::*;

    logic      raw_neg;
    flip_evt_t evt;

    zc_sign_slicer #(.SAMPLE_W(SAMPLE_W)) u_slice (
        .smp (smp_i),
        .neg (raw_neg)
    );

    zc_debounce #(.CNT_W(CNT_W)) u_dbn (
        .clk     (clk),
        .rst     (rst),
        .vld     (smp_vld_i),
        .raw_neg (raw_neg),
        .len     (dbn_len_i),
        .evt     (evt),
        .pol     (pol_o)
    );

    zc_edge_gate u_gate (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .dir (dir_i),
        .upd (upd_o)
    );
endmodule

// File: rtl/zc_checks.sv
module zc_checks (
    input logic       clk,
    input logic       rst,
    input logic       smp_vld_i,
    input logic [1:0] dir_i,
    input logic       upd_o,
    input logic       pol_o
);
    // R4
    pulse_with_flip_chk: assert property (@(posedge clk) disable iff (rst)
        upd_o |-> (pol_o != $past(pol_o)));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld_i |=> (!upd_o && $stable(pol_o)));

    // R4
    flip_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (pol_o != $past(pol_o)) |-> $past(smp_vld_i));

    // R8
    rise_only_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld_i && dir_i == 2'd1) |=> (!upd_o || !pol_o));

    // R9
    fall_only_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld_i && dir_i == 2'd2) |=> (!upd_o || pol_o));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!upd_o && !pol_o));
endmodule

bind zero_cross_detect zc_checks u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_vld_i (smp_vld_i),
    .dir_i     (dir_i),
    .upd_o     (upd_o),
    .pol_o     (pol_o)
);

// File: tb/sim_zero_cross_detect.sv
module sim_zero_cross_detect;
    localparam int SW = 16;
    localparam int CW = 8;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 vld = 1'b0;
    logic signed [SW-1:0] smp = '0;
    logic [1:0]           dir = 2'd0;
    logic [CW-1:0]        len = CW'(5);
    logic                 upd, pol;

    always #4 clk = ~clk;

    zero_cross_detect #(.SAMPLE_W(SW), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .smp_vld_i(vld), .smp_i(smp),
        .dir_i(dir), .dbn_len_i(len), .upd_o(upd), .pol_o(pol)
    );

    typedef struct {
        int    due;
        logic  e_upd;
        logic  e_pol;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_run = 0, n_fail = 0;
    bit   done = 0;

    // bench reference state
    logic m_pol = 0, m_primed = 0;
    int   m_run = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (upd !== e.e_upd || pol !== e.e_pol) begin
                n_fail++;
                $display("FAIL %s: upd=%0b pol=%0b expected upd=%0b pol=%0b",
                         e.tag, upd, pol, e.e_upd, e.e_pol);
            end
        end
    end

    // driver: called at a negedge, advances one clock
    task automatic step(input logic v, input int s, input string tag);
        logic neg, fire;
        int   need;
        exp_t e;
        vld = v;
        smp = SW'(s);
        neg = (s < 0);
        need = (len == 0) ? 1 : int'(len);
        fire = 0;
        if (v) begin
            if (!m_primed) begin
                m_primed = 1; m_pol = neg; m_run = 0;
            end else if (neg == m_pol) begin
                m_run = 0;
            end else if (m_run + 1 >= need) begin
                m_pol = neg; m_run = 0;
                fire = (dir == 2'd1) ? !neg : (dir == 2'd2) ? neg : 1'b1;
            end else begin
                m_run++;
            end
        end
        e.due = cyc + 1; e.e_upd = fire; e.e_pol = m_pol; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic run(input int s, input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, s, tag);
    endtask

    initial begin
        fork
            begin
                repeat (2) @(negedge clk);
                n_run++;
                if (upd !== 1'b0 || pol !== 1'b0) begin
                    n_fail++;
                    $display("FAIL R1: upd=%0b pol=%0b expected 0 0", upd, pol);
                end
                rst = 1'b0;
                step(1'b0, 0, "R1");
                // R2: first sample primes without pulse
                step(1'b1, -100, "R2");
                // R5: run interrupted, then full run (R4, R7)
                run(50, 4, "R5");
                step(1'b1, -7, "R5");
                run(50, 4, "R4");
                step(1'b1, 60, "R4");
                step(1'b0, 0, "R4");
                // chatter during a falling transition (R5)
                step(1'b1, -3, "R5"); step(1'b1, 2, "R5");
                step(1'b1, -1, "R5"); step(1'b1, 4, "R5");
                run(-20, 5, "R5");
                run(-20, 3, "R5");
                // R3: zero is non-negative; R6: gaps mid-run
                step(1'b1, 0, "R3"); step(1'b1, 0, "R3");
                step(1'b0, -9, "R6"); step(1'b0, -9, "R6");
                step(1'b1, 0, "R3"); step(1'b1, 0, "R6");
                step(1'b0, 5, "R6");
                step(1'b1, 0, "R3");
                step(1'b1, 0, "R3");
                // R8: rising only
                dir = 2'd1;
                run(-30, 5, "R8"); run(30, 5, "R8");
                run(-30, 5, "R8"); run(30, 5, "R8");
                // R9: falling only
                dir = 2'd2;
                run(-30, 5, "R9"); run(30, 5, "R9");
                run(-30, 5, "R9");
                // R7: code 3 acts as either
                dir = 2'd3;
                run(30, 5, "R7"); run(-30, 5, "R7");
                // R10: length 1 and 0, back-to-back flips
                dir = 2'd0;
                len = CW'(1);
                for (int i = 0; i < 6; i++) step(1'b1, (i % 2) ? -1 : 1, "R10");
                len = '0;
                for (int i = 0; i < 6; i++) step(1'b1, (i % 2) ? 1 : -1, "R10");
                // triangle wave with noise at length 3 (R4, R5)
                len = CW'(3);
                for (int i = 0; i < 160; i++) begin
                    int ph, tri_v;
                    ph = i % 40;
                    tri_v = (ph < 20) ? (ph - 10) * 10 : (30 - ph) * 10;
                    step(1'b1, tri_v + ((i % 3 == 0) ? 12 : -12), "R4");
                end
                step(1'b0, 0, "R6");
                @(negedge clk);
            end
            begin
                repeat (5000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: expired expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule